// File: doc/BRIEF.md
# Power-Management Sleep Control Register

This block is a 16-bit control register for power management, reached through a simple register bus. A write can request entry into a sleep level, raise a release event toward firmware, allow bus-master traffic to break the processor out of the C3 idle state, and choose whether power events reach the SCI or the SMI interrupt line. A read returns the current register contents at all times.

The register's fields sit in three reset domains. The sleep-type field survives everything except the RTC-domain reset. The bus-master reload enable is cleared by the PCI reset. The interrupt-routing bit and the sleep-level state are cleared by the core reset. When sleep entry is triggered, the 3-bit sleep type is decoded into four cumulative active-low sleep-level outputs. These outputs then hold until a wake input clears them. Sequencing of platform power rails and the interrupt controllers are outside this block.

Top module: `pmc_sleep_ctl`

## Requirements
- R1: While `rtc_rst`, `pci_rst` and `core_rst` are all high, `rd_data` reads 0x0000, `slp_lvl_n` reads 4'hF and `fw_rls_pulse` is 0.
- R2: Bits 15:14 and 9:3 read as zero whatever is written. The write-only bits 13 (sleep go) and 2 (firmware release) also always read as zero.
- R3: Bits 12:10 hold the sleep-type code. This field is read/write and is loaded from `wr_data[12:10]` on a write with `wr_be[1]` set.
- R4: The sleep-type field keeps its value through `pci_rst` and `core_rst`. Only `rtc_rst` clears it to 000.
- R5: A write with `wr_be[1]` set and `wr_data[13]` = 1 updates `slp_lvl_n` at the clock edge that takes the write, using the sleep type carried in the same write. `slp_lvl_n[0]`, `[1]`, `[2]` and `[3]` are the active-low S1, S3, S4 and S5 levels. The codes decode as follows: 000 asserts none, 010 asserts S1, 101 asserts S1 and S3, 110 asserts S1, S3 and S4, and 111 asserts all four.
- R6: Sleep entry with one of the reserved codes 001, 011 or 100 asserts no sleep-level output.
- R7: The sleep levels hold their pattern when the sleep-type field is rewritten without bit 13. They return to 4'hF on the edge after `wake` is high, and `wake` wins over a simultaneous entry. `core_rst` also returns them to 4'hF.
- R8: A write with `wr_be[0]` set and `wr_data[2]` = 1 makes `fw_rls_pulse` high for exactly the one cycle after the edge that takes the write.
- R9: Bit 1 is the bus-master reload enable. It is read/write and cleared only by `pci_rst`. `c3_break` follows `bm_req` while bit 1 is 1 and stays 0 while bit 1 is 0.
- R10: Bit 0 selects the routing and is cleared by `core_rst`. With bit 0 at 0, `pwr_evt` appears on `smi_evt`. With bit 0 at 1, `pwr_evt` appears on `sci_evt`. The two outputs are never high together.
- R11: A write with only `wr_be[0]` set leaves bits 12:10 and the sleep levels unchanged. A write with only `wr_be[1]` set leaves bits 1:0 unchanged and raises no release pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst | input | 1 | Synchronous active-high RTC-domain reset |
| pci_rst | input | 1 | Synchronous active-high PCI-domain reset |
| core_rst | input | 1 | Synchronous active-high core-domain reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register readback |
| bm_req | input | 1 | Bus-master request |
| wake | input | 1 | Wake event that clears the sleep levels |
| pwr_evt | input | 1 | Power event to be routed |
| slp_lvl_n | output | 4 | Active-low S1, S3, S4, S5 levels (bits 0..3) |
| fw_rls_pulse | output | 1 | One-cycle release event toward firmware |
| c3_break | output | 1 | Break-from-C3 request |
| sci_evt | output | 1 | Power event routed to SCI |
| smi_evt | output | 1 | Power event routed to SMI |

## Verification
The assertions watch several properties on every cycle. Reserved and write-only bits must read as zero. The sleep levels must stay cumulative and must clear after a wake. The two interrupt routes must be exclusive. The C3 break must stay gated off while its enable is clear. A release pulse must always trace back to a qualifying write. The full decode table needs the bench's scenarios, because the assertions cannot show it completely. The same holds for survival of the sleep type across each individual reset domain, for the pattern holding while the type field is rewritten, and for the byte-enable cases.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int REG_W      = 16;
    localparam int NUM_LVLS   = 4;
    localparam int BE_W       = REG_W / 8;
    localparam int STYP_W     = 3;
    localparam int STYP_LSB   = 10;
    localparam int STYP_MSB   = STYP_LSB + STYP_W - 1;
    localparam int BIT_SLPGO  = 13;
    localparam int BIT_RLS    = 2;
    localparam int BIT_BMRLD  = 1;
    localparam int BIT_ROUTE  = 0;
    localparam int BE_HI      = 1;
    localparam int BE_LO      = 0;

    typedef enum logic [STYP_W-1:0] {
        STYP_WORK  = 3'b000,
        STYP_RSV1  = 3'b001,
        STYP_LIGHT = 3'b010,
        STYP_RSV3  = 3'b011,
        STYP_RSV4  = 3'b100,
        STYP_RAM   = 3'b101,
        STYP_DISK  = 3'b110,
        STYP_OFF   = 3'b111
    } styp_e;

    // active-high level vector, bit 0 = S1 ... bit 3 = S5
    typedef logic [NUM_LVLS-1:0] lvl_vec_t;

    typedef struct packed {
        logic  hi_we;
        logic  lo_we;
        styp_e styp;
        logic  slp_go;
        logic  rls_go;
        logic  bm_rld;
        logic  route_sci;
    } wr_cmd_t;

    function automatic lvl_vec_t styp_decode(input styp_e t);
        lvl_vec_t v;
        case (t)
            STYP_LIGHT: v = 4'b0001;
            STYP_RAM:   v = 4'b0011;
            STYP_DISK:  v = 4'b0111;
            STYP_OFF:   v = 4'b1111;
            default:    v = 4'b0000;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/pmc_wr_decode.sv
module pmc_wr_decode
    import pmc_pkg::*;
(
    input  logic             wr_en,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [REG_W-1:0] wr_data,
    output wr_cmd_t          cmd
);
    logic unused_rsvd;
    assign unused_rsvd = ^{wr_data[15:14], wr_data[9:3]};

    always_comb begin
        cmd.hi_we     = wr_en & wr_be[BE_HI];
        cmd.lo_we     = wr_en & wr_be[BE_LO];
        cmd.styp      = styp_e'(wr_data[STYP_MSB:STYP_LSB]);
        cmd.slp_go    = cmd.hi_we & wr_data[BIT_SLPGO];
        cmd.rls_go    = cmd.lo_we & wr_data[BIT_RLS];
        cmd.bm_rld    = wr_data[BIT_BMRLD];
        cmd.route_sci = wr_data[BIT_ROUTE];
    end
endmodule

// File: rtl/pmc_ctl_regs.sv
module pmc_ctl_regs
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rtc_rst,
    input  logic             pci_rst,
    input  logic             core_rst,
    input  wr_cmd_t          cmd,
    output styp_e            styp_q,
    output logic             bm_rld_q,
    output logic             route_sci_q,
    output logic [REG_W-1:0] rd_data
);
    // RTC domain: sleep type
    always_ff @(posedge clk) begin
        if (rtc_rst)        styp_q <= STYP_WORK;
        else if (cmd.hi_we) styp_q <= cmd.styp;
    end

    // PCI domain: bus-master reload enable
    always_ff @(posedge clk) begin
        if (pci_rst)        bm_rld_q <= 1'b0;
        else if (cmd.lo_we) bm_rld_q <= cmd.bm_rld;
    end

    // core domain: interrupt routing select
    always_ff @(posedge clk) begin
        if (core_rst)       route_sci_q <= 1'b0;
        else if (cmd.lo_we) route_sci_q <= cmd.route_sci;
    end

    // readback: every bit not named below reads zero
    always_comb begin
        rd_data                     = '0;
        rd_data[STYP_MSB:STYP_LSB]  = styp_q;
        rd_data[BIT_BMRLD]          = bm_rld_q;
        rd_data[BIT_ROUTE]          = route_sci_q;
    end
endmodule

// File: rtl/pmc_sleep_seq.sv
module pmc_sleep_seq
    import pmc_pkg::*;
(
    input  logic                clk,
    input  logic                core_rst,
    input  logic                slp_go,
    input  styp_e               styp_new,
    input  logic                wake,
    output logic [NUM_LVLS-1:0] slp_lvl_n
);
    lvl_vec_t lvl_q;

    always_ff @(posedge clk) begin
        if (core_rst)    lvl_q <= '0;
        else if (wake)   lvl_q <= '0;
        else if (slp_go) lvl_q <= styp_decode(styp_new);
    end

    for (genvar g = 0; g < NUM_LVLS; g++) begin : g_lvl_pin
        assign slp_lvl_n[g] = ~lvl_q[g];
    end
endmodule

// File: rtl/pmc_evt_route.sv
module pmc_evt_route
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic core_rst,
    input  logic rls_go,
    input  logic bm_rld_q,
    input  logic route_sci_q,
    input  logic bm_req,
    input  logic pwr_evt,
    output logic fw_rls_pulse,
    output logic c3_break,
    output logic sci_evt,
    output logic smi_evt
);
    always_ff @(posedge clk) begin
        if (core_rst) fw_rls_pulse <= 1'b0;
        else          fw_rls_pulse <= rls_go;
    end

    always_comb begin
        c3_break = bm_req & bm_rld_q;
        sci_evt  = pwr_evt & route_sci_q;
        smi_evt  = pwr_evt & ~route_sci_q;
    end
endmodule

// File: rtl/pmc_sleep_ctl.sv
module pmc_sleep_ctl
    import pmc_pkg::*;
(
    input  logic                clk,
    input  logic                rtc_rst,
    input  logic                pci_rst,
    input  logic                core_rst,
    input  logic                wr_en,
    input  logic [BE_W-1:0]     wr_be,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic                bm_req,
    input  logic                wake,
    input  logic                pwr_evt,
    output logic [NUM_LVLS-1:0] slp_lvl_n,
    output logic                fw_rls_pulse,
    output logic                c3_break,
    output logic                sci_evt,
    output logic                smi_evt
);
    wr_cmd_t cmd;
    styp_e   styp_q;
    logic    bm_rld_q;
    logic    route_sci_q;

    pmc_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    pmc_ctl_regs u_regs (
        .clk         (clk),
        .rtc_rst     (rtc_rst),
        .pci_rst     (pci_rst),
        .core_rst    (core_rst),
        .cmd         (cmd),
        .styp_q      (styp_q),
        .bm_rld_q    (bm_rld_q),
        .route_sci_q (route_sci_q),
        .rd_data     (rd_data)
    );

    pmc_sleep_seq u_seq (
        .clk       (clk),
        .core_rst  (core_rst),
        .slp_go    (cmd.slp_go),
        .styp_new  (cmd.styp),
        .wake      (wake),
        .slp_lvl_n (slp_lvl_n)
    );

    pmc_evt_route u_route (
        .clk          (clk),
        .core_rst     (core_rst),
        .rls_go       (cmd.rls_go),
        .bm_rld_q     (bm_rld_q),
        .route_sci_q  (route_sci_q),
        .bm_req       (bm_req),
        .pwr_evt      (pwr_evt),
        .fw_rls_pulse (fw_rls_pulse),
        .c3_break     (c3_break),
        .sci_evt      (sci_evt),
        .smi_evt      (smi_evt)
    );

    logic unused_styp;
    assign unused_styp = ^styp_q;
endmodule

// File: rtl/pmc_sleep_ctl_chk.sv
module pmc_sleep_ctl_chk (
    input logic        clk,
    input logic        rtc_rst,
    input logic        pci_rst,
    input logic        core_rst,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        bm_req,
    input logic        wake,
    input logic        pwr_evt,
    input logic [3:0]  slp_lvl_n,
    input logic        fw_rls_pulse,
    input logic        c3_break,
    input logic        sci_evt,
    input logic        smi_evt
);
    logic any_rst;
    assign any_rst = rtc_rst | pci_rst | core_rst;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (any_rst)
        (rd_data[15:13] == 3'b000) && (rd_data[9:2] == 8'h00));

    p_styp_load_r3: assert property (@(posedge clk) disable iff (rtc_rst)
        (wr_en && wr_be[1]) |=> (rd_data[12:10] == $past(wr_data[12:10])));

    p_styp_keep_r4: assert property (@(posedge clk) disable iff (rtc_rst)
        ((pci_rst || core_rst) && !(wr_en && wr_be[1])) |=> $stable(rd_data[12:10]));

    p_lvl_cumul_r5: assert property (@(posedge clk) disable iff (core_rst)
        (slp_lvl_n == 4'hF) || (slp_lvl_n == 4'hE) || (slp_lvl_n == 4'hC) ||
        (slp_lvl_n == 4'h8) || (slp_lvl_n == 4'h0));

    p_off_entry_r5: assert property (@(posedge clk) disable iff (core_rst)
        (wr_en && wr_be[1] && wr_data[13] && !wake && wr_data[12:10] == 3'b111)
        |=> (slp_lvl_n == 4'h0));

    p_rsvd_code_r6: assert property (@(posedge clk) disable iff (core_rst)
        (wr_en && wr_be[1] && wr_data[13] &&
         (wr_data[12:10] == 3'b001 || wr_data[12:10] == 3'b011 || wr_data[12:10] == 3'b100))
        |=> (slp_lvl_n == 4'hF));

    p_wake_clear_r7: assert property (@(posedge clk) disable iff (core_rst)
        wake |=> (slp_lvl_n == 4'hF));

    p_rls_cause_r8: assert property (@(posedge clk) disable iff (core_rst)
        fw_rls_pulse |-> $past(wr_en && wr_be[0] && wr_data[2]));

    p_c3_gate_r9: assert property (@(posedge clk) disable iff (any_rst)
        !rd_data[1] |-> !c3_break);

    p_route_excl_r10: assert property (@(posedge clk) disable iff (any_rst)
        pwr_evt |-> (sci_evt != smi_evt));

    p_hi_keep_r11: assert property (@(posedge clk) disable iff (any_rst)
        (wr_en && !wr_be[1]) |=> $stable(rd_data[12:10]));
endmodule

bind pmc_sleep_ctl pmc_sleep_ctl_chk u_chk (.*);

// File: tb/pmc_sleep_ctl_bench.sv
module pmc_sleep_ctl_bench;
    logic        clk = 1'b0;
    logic        rtc_rst = 1'b1, pci_rst = 1'b1, core_rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        bm_req = 1'b0, wake = 1'b0, pwr_evt = 1'b0;
    logic [3:0]  slp_lvl_n;
    logic        fw_rls_pulse, c3_break, sci_evt, smi_evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pmc_sleep_ctl u_pmc_sleep_ctl (.*);

    // {be[1:0], wr_data[15:0], expected rd_data[15:0], expected slp_lvl_n[3:0]}
    localparam logic [37:0] VEC [12] = '{
        {2'b11, 16'h2000, 16'h0000, 4'hF},  // R5 code 000
        {2'b11, 16'h2800, 16'h0800, 4'hE},  // R5 code 010
        {2'b11, 16'h3400, 16'h1400, 4'hC},  // R5 code 101
        {2'b11, 16'h3800, 16'h1800, 4'h8},  // R5 code 110
        {2'b11, 16'h3C00, 16'h1C00, 4'h0},  // R5 code 111
        {2'b11, 16'h2400, 16'h0400, 4'hF},  // R6 code 001
        {2'b11, 16'h2C00, 16'h0C00, 4'hF},  // R6 code 011
        {2'b11, 16'h3000, 16'h1000, 4'hF},  // R6 code 100
        {2'b11, 16'hFFFF, 16'h1C03, 4'h0},  // R2 reserved bits
        {2'b01, 16'hFFFF, 16'h1C03, 4'hF},  // R11 low byte only
        {2'b01, 16'h0000, 16'h1C00, 4'hF},  // R11 low byte clears 1:0
        {2'b10, 16'h0000, 16'h0000, 4'hF}   // R3 high byte without go
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 slp_lvl_n", {12'h0, slp_lvl_n}, 16'h000F);
        chk("R1 fw_rls_pulse", {15'h0, fw_rls_pulse}, 16'h0000);
        rtc_rst = 1'b0; pci_rst = 1'b0; core_rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][37:36], VEC[i][35:20]);
            chk($sformatf("R3/R5 vec%0d rd_data", i), rd_data, VEC[i][19:4]);
            chk($sformatf("R5/R6 vec%0d slp_lvl_n", i), {12'h0, slp_lvl_n}, {12'h0, VEC[i][3:0]});
            pulse_wake();
            chk($sformatf("R7 vec%0d wake", i), {12'h0, slp_lvl_n}, 16'h000F);
        end

        // R8: one-cycle release pulse, reads back zero
        wr(2'b01, 16'h0004);
        chk("R8 pulse high", {15'h0, fw_rls_pulse}, 16'h0001);
        chk("R2 bit2 reads zero", rd_data, 16'h0000);
        @(negedge clk);
        chk("R8 pulse one cycle", {15'h0, fw_rls_pulse}, 16'h0000);
        // R11: high byte only gives no pulse
        wr(2'b10, 16'h0004);
        chk("R11 no pulse", {15'h0, fw_rls_pulse}, 16'h0000);

        // R4: reset domains
        wr(2'b11, 16'h1803);
        @(negedge clk); pci_rst = 1'b1; @(negedge clk); pci_rst = 1'b0;
        chk("R4/R9 after pci_rst", rd_data, 16'h1801);
        @(negedge clk); core_rst = 1'b1; @(negedge clk); core_rst = 1'b0;
        chk("R4/R10 after core_rst", rd_data, 16'h1800);
        @(negedge clk); rtc_rst = 1'b1; @(negedge clk); rtc_rst = 1'b0;
        chk("R4 after rtc_rst", rd_data, 16'h0000);

        // R7: hold while type rewritten, wake wins, core reset clears
        wr(2'b10, 16'h3400);
        wr(2'b10, 16'h1C00);
        chk("R7 hold on rewrite", {12'h0, slp_lvl_n}, 16'h000C);
        @(negedge clk);
        wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h3C00; wake = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0; wake = 1'b0;
        chk("R7 wake wins", {12'h0, slp_lvl_n}, 16'h000F);
        wr(2'b10, 16'h3C00);
        chk("R7 entered", {12'h0, slp_lvl_n}, 16'h0000);
        @(negedge clk); core_rst = 1'b1; @(negedge clk); core_rst = 1'b0;
        chk("R7 core_rst clears", {12'h0, slp_lvl_n}, 16'h000F);

        // R9: C3 break gating
        bm_req = 1'b1;
        @(negedge clk);
        chk("R9 disabled", {15'h0, c3_break}, 16'h0000);
        wr(2'b01, 16'h0002);
        chk("R9 enabled", {15'h0, c3_break}, 16'h0001);
        bm_req = 1'b0; #1;
        chk("R9 follows req", {15'h0, c3_break}, 16'h0000);

        // R10: routing
        pwr_evt = 1'b1;
        wr(2'b01, 16'h0000);
        chk("R10 smi route", {14'h0, sci_evt, smi_evt}, 16'h0001);
        wr(2'b01, 16'h0001);
        chk("R10 sci route", {14'h0, sci_evt, smi_evt}, 16'h0002);
        pwr_evt = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule